// File: doc/BRIEF.md
# Quad-Widening Multiply-Accumulate Unit

This block is a lane-parallel integer multiply-accumulate datapath for a vector pipeline. In every enabled lane it multiplies two narrow integer elements exactly and adds the product to an accumulator four times as wide as one element. The updated accumulator vector replaces the old one and is registered with a one-cycle valid. Each multiplier operand has its own signed or unsigned interpretation. The first operand comes either from a per-lane vector or from one scalar broadcast to every lane.

The accumulator bus is built from `SLICES` 64-bit slices. With `wide_sel` low, each slice holds two 32-bit accumulators fed by 8-bit elements. With `wide_sel` high, each slice holds one 64-bit accumulator fed by 16-bit elements. The operand buses are `16*SLICES` bits wide in both cases. `WIDE_EN` sets whether the 16-bit form exists. When it is 0, only the 8-bit form is supported.

Illegal requests produce an error pulse in place of a valid and leave every accumulator unchanged. Decoding, register access and vector-length handling are left to the surrounding pipeline.

Top module: `qmac_unit`

## Requirements
- R1: With `wide_sel`=0 there are 2*SLICES lanes. Lane i takes operand A from `op_a_vec[8i+7:8i]`, operand B from `op_b_vec[8i+7:8i]` and the accumulator from `acc_in[32i+31:32i]`. Its result is accumulator plus the A*B product, placed at the same position in `acc_out`.
- R2: With `wide_sel`=1 and `WIDE_EN`=1 there are SLICES lanes. Lane j uses the 16-bit fields `[16j+15:16j]` of the operand buses and the 64-bit field `[64j+63:64j]` of the accumulator buses.
- R3: `mode` sets operand signedness: 2'b00 both unsigned, 2'b01 both signed, 2'b10 A signed and B unsigned, 2'b11 A unsigned and B signed. Each product is exact under that interpretation.
- R4: With `scalar_src`=1, every lane uses the low element-width bits of `scalar_op` as operand A, and `op_a_vec` has no effect.
- R5: A lane whose mask bit is 0 (bit i of `mask` for lane i, in both widths) keeps its accumulator unchanged. In wide mode, mask bits at or above SLICES have no effect.
- R6: `mode`=2'b11 with `scalar_src`=0 is illegal. The cycle after such a request, `out_err` is 1, `out_valid` is 0 and `acc_out` equals the `acc_in` of the request.
- R7: Accumulation wraps modulo 2 to the power of the accumulator width. It does not saturate.
- R8: `out_valid` is 1 exactly one cycle after a legal request with `in_valid`=1. In a cycle after `in_valid`=0, both `out_valid` and `out_err` are 0 and `acc_out` holds its value. `out_valid` and `out_err` are never 1 together.
- R9: While synchronous active-low `rst_n` is 0, the next edge clears `out_valid`, `out_err` and `acc_out`.
- R10: With `WIDE_EN`=0, a request with `wide_sel`=1 is illegal and behaves as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| wide_sel | input | 1 | 0: 8-bit elements/32-bit accumulators; 1: 16-bit/64-bit |
| mode | input | 2 | Operand signedness code |
| scalar_src | input | 1 | Use broadcast scalar for operand A |
| scalar_op | input | 16 | Broadcast scalar operand A |
| op_a_vec | input | 16*SLICES | Per-lane operand A |
| op_b_vec | input | 16*SLICES | Per-lane operand B |
| acc_in | input | 64*SLICES | Accumulators to update |
| mask | input | 2*SLICES | Per-lane enable |
| out_valid | output | 1 | Registered result valid |
| out_err | output | 1 | Illegal-request pulse |
| acc_out | output | 64*SLICES | Registered updated accumulators |

## Verification
The bench builds two instances with SLICES=2, giving four narrow lanes and two wide lanes. One instance has `WIDE_EN`=1 and the other has `WIDE_EN`=0, and both receive the same stimulus. Two slices make it possible to see that lanes in both element widths use the right bus fields and do not interfere with each other. The instance without the wide form shows that 16-bit requests are rejected while 8-bit requests still behave the same as in the full instance.

// File: rtl/qmac_pkg.sv
package qmac_pkg;
   localparam int NARROW_EW = 8;
   localparam int WIDE_EW   = 16;
   localparam int SLICE_W   = 64;

   typedef enum logic [1:0] {
      QM_UU = 2'b00,
      QM_SS = 2'b01,
      QM_SU = 2'b10,
      QM_US = 2'b11
   } qmac_mode_e;

   function automatic logic a_signed(input qmac_mode_e m);
      return (m == QM_SS) || (m == QM_SU);
   endfunction

   function automatic logic b_signed(input qmac_mode_e m);
      return (m == QM_SS) || (m == QM_US);
   endfunction
endpackage

// File: rtl/qmac_lane.sv
module qmac_lane #(
   parameter int EW = 8
) (
   input  logic [EW-1:0]   a_i,
   input  logic [EW-1:0]   b_i,
   input  logic            a_sgn_i,
   input  logic            b_sgn_i,
   input  logic            en_i,
   input  logic [4*EW-1:0] acc_i,
   output logic [4*EW-1:0] acc_o
);
   localparam int PW = 2*EW + 2;
   localparam int AW = 4*EW;

   if (EW < 2) begin : g_bad_ew
      $error("qmac_lane: EW must be at least 2");
   end

   logic signed [EW:0]   a_x, b_x;
   logic signed [PW-1:0] a_w, b_w, prod;
   logic        [AW-1:0] prod_ext;

   // one extra bit carries the per-operand sign choice
   assign a_x      = $signed({a_sgn_i & a_i[EW-1], a_i});
   assign b_x      = $signed({b_sgn_i & b_i[EW-1], b_i});
   assign a_w      = {{(PW-EW-1){a_x[EW]}}, a_x};
   assign b_w      = {{(PW-EW-1){b_x[EW]}}, b_x};
   assign prod     = a_w * b_w;
   assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
   assign acc_o    = en_i ? (acc_i + prod_ext) : acc_i;
endmodule

// File: rtl/qmac_legal.sv
module qmac_legal #(
   parameter bit WIDE_EN = 1'b1
) (
   input  logic [1:0] mode_i,
   input  logic       scalar_src_i,
   input  logic       wide_sel_i,
   output logic       legal_o
);
   import qmac_pkg::*;
   logic width_ok;

   if (WIDE_EN) begin : g_wide_ok
      assign width_ok = 1'b1;
   end else begin : g_narrow_only
      assign width_ok = ~wide_sel_i;
   end

   // unsigned-A / signed-B only pairs with a broadcast scalar
   assign legal_o = width_ok && !((qmac_mode_e'(mode_i) == QM_US) && !scalar_src_i);
endmodule

// File: rtl/qmac_unit.sv
module qmac_unit #(
   parameter int SLICES  = 2,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   wide_sel,
   input  logic [1:0]             mode,
   input  logic                   scalar_src,
   input  logic [15:0]            scalar_op,
   input  logic [16*SLICES-1:0]   op_a_vec,
   input  logic [16*SLICES-1:0]   op_b_vec,
   input  logic [64*SLICES-1:0]   acc_in,
   input  logic [2*SLICES-1:0]    mask,
   output logic                   out_valid,
   output logic                   out_err,
   output logic [64*SLICES-1:0]   acc_out
);
   import qmac_pkg::*;

   localparam int NEW  = NARROW_EW;
   localparam int WEW  = WIDE_EW;
   localparam int NL   = SLICE_W / (4*NEW) * SLICES;
   localparam int WL   = SLICE_W / (4*WEW) * SLICES;
   localparam int ACCW = SLICE_W * SLICES;

   if (SLICES < 1) begin : g_bad_slices
      $error("qmac_unit: SLICES must be at least 1");
   end
   if (NL != 2*SLICES) begin : g_bad_geom
      $error("qmac_unit: lane geometry does not match mask width");
   end

   logic            a_sg, b_sg, legal;
   logic [ACCW-1:0] narrow_res, wide_res, next_acc;

   assign a_sg = a_signed(qmac_mode_e'(mode));
   assign b_sg = b_signed(qmac_mode_e'(mode));

   qmac_legal #(.WIDE_EN(WIDE_EN)) u_legal (
      .mode_i       (mode),
      .scalar_src_i (scalar_src),
      .wide_sel_i   (wide_sel),
      .legal_o      (legal)
   );

   for (genvar i = 0; i < NL; i++) begin : g_nlane
      logic [NEW-1:0] a_sel;
      assign a_sel = scalar_src ? scalar_op[NEW-1:0] : op_a_vec[NEW*i +: NEW];
      qmac_lane #(.EW(NEW)) u_lane (
         .a_i     (a_sel),
         .b_i     (op_b_vec[NEW*i +: NEW]),
         .a_sgn_i (a_sg),
         .b_sgn_i (b_sg),
         .en_i    (mask[i]),
         .acc_i   (acc_in[4*NEW*i +: 4*NEW]),
         .acc_o   (narrow_res[4*NEW*i +: 4*NEW])
      );
   end

   if (WIDE_EN) begin : g_wide
      for (genvar j = 0; j < WL; j++) begin : g_wlane
         logic [WEW-1:0] a_sel;
         assign a_sel = scalar_src ? scalar_op : op_a_vec[WEW*j +: WEW];
         qmac_lane #(.EW(WEW)) u_lane (
            .a_i     (a_sel),
            .b_i     (op_b_vec[WEW*j +: WEW]),
            .a_sgn_i (a_sg),
            .b_sgn_i (b_sg),
            .en_i    (mask[j]),
            .acc_i   (acc_in[4*WEW*j +: 4*WEW]),
            .acc_o   (wide_res[4*WEW*j +: 4*WEW])
         );
      end
   end else begin : g_no_wide
      assign wide_res = acc_in;
   end

   always_comb begin
      next_acc = acc_in;
      if (legal) next_acc = wide_sel ? wide_res : narrow_res;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         acc_out   <= '0;
      end else begin
         out_valid <= in_valid & legal;
         out_err   <= in_valid & ~legal;
         if (in_valid) acc_out <= next_acc;
      end
   end
endmodule

// File: rtl/qmac_unit_chk.sv
module qmac_unit_chk #(
   parameter int SLICES  = 2,
   parameter bit WIDE_EN = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 wide_sel,
   input logic [1:0]           mode,
   input logic                 scalar_src,
   input logic [15:0]          scalar_op,
   input logic [7:0]           op_a_lo,
   input logic [15:0]          op_b_lo,
   input logic [64*SLICES-1:0] acc_in,
   input logic                 mask0,
   input logic                 out_valid,
   input logic                 out_err,
   input logic [64*SLICES-1:0] acc_out
);
   logic bad_req;
   assign bad_req = (mode == 2'b11 && !scalar_src) || (wide_sel && !WIDE_EN);

   p_valid_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !bad_req |=> out_valid && !out_err);

   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_err && acc_out == $past(acc_out));

   p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_err));

   p_illegal_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && mode == 2'b11 && !scalar_src |=> out_err && !out_valid && acc_out == $past(acc_in));

   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !wide_sel && !mask0 |=> acc_out[31:0] == $past(acc_in[31:0]));

   p_uu_lane0_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !wide_sel && mask0 && mode == 2'b00 && !scalar_src
      |=> acc_out[31:0] == $past(acc_in[31:0] + ({24'd0, op_a_lo} * {24'd0, op_b_lo[7:0]})));

   if (WIDE_EN) begin : g_wide_chk
      p_ss_scalar_r2: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && wide_sel && mask0 && mode == 2'b01 && scalar_src
         |=> acc_out[63:0] == $past(acc_in[63:0] +
             ({{48{scalar_op[15]}}, scalar_op} * {{48{op_b_lo[15]}}, op_b_lo})));
   end else begin : g_narrow_chk
      p_wide_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && wide_sel |=> out_err && !out_valid && acc_out == $past(acc_in));
   end
endmodule

bind qmac_unit qmac_unit_chk #(.SLICES(SLICES), .WIDE_EN(WIDE_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .wide_sel   (wide_sel),
   .mode       (mode),
   .scalar_src (scalar_src),
   .scalar_op  (scalar_op),
   .op_a_lo    (op_a_vec[7:0]),
   .op_b_lo    (op_b_vec[15:0]),
   .acc_in     (acc_in),
   .mask0      (mask[0]),
   .out_valid  (out_valid),
   .out_err    (out_err),
   .acc_out    (acc_out)
);

// File: tb/tb_qmac_unit.sv
module tb_qmac_unit;
   localparam int S    = 2;
   localparam int NL   = 2*S;
   localparam int OPW  = 16*S;
   localparam int ACCW = 64*S;

   logic            clk, rst_n, in_valid, wide_sel, scalar_src;
   logic [1:0]      mode;
   logic [15:0]     scalar_op;
   logic [OPW-1:0]  op_a_vec, op_b_vec;
   logic [ACCW-1:0] acc_in;
   logic [NL-1:0]   mask;
   logic            ov, oe, ov_n, oe_n;
   logic [ACCW-1:0] acc_o, acc_o_n;

   qmac_unit #(.SLICES(S), .WIDE_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel), .mode(mode),
      .scalar_src(scalar_src), .scalar_op(scalar_op), .op_a_vec(op_a_vec), .op_b_vec(op_b_vec),
      .acc_in(acc_in), .mask(mask), .out_valid(ov), .out_err(oe), .acc_out(acc_o));

   qmac_unit #(.SLICES(S), .WIDE_EN(1'b0)) dut_narrow (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel), .mode(mode),
      .scalar_src(scalar_src), .scalar_op(scalar_op), .op_a_vec(op_a_vec), .op_b_vec(op_b_vec),
      .acc_in(acc_in), .mask(mask), .out_valid(ov_n), .out_err(oe_n), .acc_out(acc_o_n));

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int    n_checks = 0;
   int    n_fail   = 0;
   string cur_tag  = "R9";
   bit    started  = 0;

   logic            e_v, e_e, e_v_n, e_e_n;
   logic [ACCW-1:0] e_acc, e_acc_n;
   string           e_tag, e_tag_n;

   // behavioural model: returns {error, accumulators}
   function automatic logic [ACCW:0] ref_step(input logic wide, input logic [1:0] md,
         input logic ss, input logic [15:0] sc, input logic [OPW-1:0] a, input logic [OPW-1:0] b,
         input logic [ACCW-1:0] acc, input logic [NL-1:0] m, input bit wide_en);
      logic [ACCW-1:0] r;
      bit illegal;
      illegal = (md == 2'b11 && !ss) || (wide && !wide_en);
      r = acc;
      if (!illegal && !wide) begin
         for (int i = 0; i < NL; i++) begin
            logic [7:0] a8, b8;
            longint av, bv, p;
            a8 = ss ? sc[7:0] : a[8*i +: 8];
            b8 = b[8*i +: 8];
            if (md == 2'b01 || md == 2'b10) av = longint'($signed(a8)); else av = longint'({56'd0, a8});
            if (md == 2'b01 || md == 2'b11) bv = longint'($signed(b8)); else bv = longint'({56'd0, b8});
            p = av * bv;
            if (m[i]) r[32*i +: 32] = acc[32*i +: 32] + p[31:0];
         end
      end else if (!illegal) begin
         for (int j = 0; j < S; j++) begin
            logic [15:0] a16, b16;
            longint av, bv, p;
            a16 = ss ? sc : a[16*j +: 16];
            b16 = b[16*j +: 16];
            if (md == 2'b01 || md == 2'b10) av = longint'($signed(a16)); else av = longint'({48'd0, a16});
            if (md == 2'b01 || md == 2'b11) bv = longint'($signed(b16)); else bv = longint'({48'd0, b16});
            p = av * bv;
            if (m[j]) r[64*j +: 64] = acc[64*j +: 64] + 64'(p);
         end
      end
      return {illegal, r};
   endfunction

   always @(posedge clk) begin
      logic [ACCW:0] res;
      if (!rst_n) begin
         e_v = 0; e_e = 0; e_acc = '0; e_v_n = 0; e_e_n = 0; e_acc_n = '0;
         e_tag = "R9"; e_tag_n = "R9";
      end else if (in_valid) begin
         res = ref_step(wide_sel, mode, scalar_src, scalar_op, op_a_vec, op_b_vec, acc_in, mask, 1'b1);
         e_e = res[ACCW]; e_v = !res[ACCW]; e_acc = res[ACCW-1:0]; e_tag = cur_tag;
         res = ref_step(wide_sel, mode, scalar_src, scalar_op, op_a_vec, op_b_vec, acc_in, mask, 1'b0);
         e_e_n = res[ACCW]; e_v_n = !res[ACCW]; e_acc_n = res[ACCW-1:0];
         e_tag_n = wide_sel ? "R10" : cur_tag;
      end else begin
         e_v = 0; e_e = 0; e_v_n = 0; e_e_n = 0;
         e_tag = cur_tag; e_tag_n = cur_tag;
      end
      started = 1;
   end

   task automatic cmp(input string tag, input string who, input logic v, input logic ev,
                      input logic er, input logic ee, input logic [ACCW-1:0] a, input logic [ACCW-1:0] ea);
      n_checks++;
      if (v !== ev || er !== ee || a !== ea) begin
         n_fail++;
         $display("FAIL %s %s: valid=%0b err=%0b acc=%h expected valid=%0b err=%0b acc=%h",
                  tag, who, v, er, a, ev, ee, ea);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         cmp(e_tag, "dut", ov, e_v, oe, e_e, acc_o, e_acc);
         cmp(e_tag_n, "dut_narrow", ov_n, e_v_n, oe_n, e_e_n, acc_o_n, e_acc_n);
      end
   end

   task automatic drive(input string tag, input logic v, input logic w, input logic [1:0] md,
         input logic ss, input logic [15:0] sc, input logic [OPW-1:0] a, input logic [OPW-1:0] b,
         input logic [ACCW-1:0] acc, input logic [NL-1:0] m);
      @(negedge clk);
      cur_tag = tag; in_valid = v; wide_sel = w; mode = md; scalar_src = ss;
      scalar_op = sc; op_a_vec = a; op_b_vec = b; acc_in = acc; mask = m;
   endtask

   function automatic logic [ACCW-1:0] rnd_acc();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic rnd_req(input string tag, input logic w, input logic [1:0] md,
                          input logic ss, input logic [NL-1:0] m);
      drive(tag, 1'b1, w, md, ss, 16'($urandom), $urandom, $urandom, rnd_acc(), m);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      rst_n = 0;
      drive("R9", 1'b1, 1'b0, 2'b00, 1'b0, 16'hFFFF, '1, '1, '1, '1);
      drive("R9", 1'b1, 1'b1, 2'b01, 1'b1, 16'h1234, '1, '1, '1, '1);
      drive("R9", 1'b0, 1'b0, 2'b00, 1'b0, 16'h0, '0, '0, '0, '0);
      rst_n = 1;
      drive("R9", 1'b0, 1'b0, 2'b00, 1'b0, 16'h0, '0, '0, '0, '0);
      // R1 directed narrow unsigned, each lane distinct
      drive("R1", 1'b1, 1'b0, 2'b00, 1'b0, 16'h0,
            32'h04030201, 32'h40302010, 128'h00000004_00000003_00000002_00000001, 4'hF);
      for (int k = 0; k < 20; k++) rnd_req("R1", 1'b0, 2'b00, 1'b0, 4'hF);
      // R3 every mode in both widths
      for (int md = 0; md < 4; md++)
         for (int k = 0; k < 15; k++) begin
            rnd_req("R3", 1'b0, 2'(md), md == 3, 4'hF);
            rnd_req("R3", 1'b1, 2'(md), md == 3, 4'hF);
         end
      drive("R3", 1'b1, 1'b0, 2'b01, 1'b0, 16'h0, 32'h80808080, 32'h7F80FF80, '0, 4'hF);
      drive("R3", 1'b1, 1'b1, 2'b10, 1'b0, 16'h0, 32'h8000FFFF, 32'hFFFFFFFF, '0, 4'hF);
      // R2 wide lanes
      drive("R2", 1'b1, 1'b1, 2'b00, 1'b0, 16'h0, 32'hFFFF0003, 32'hFFFF0005,
            128'h0000000000000010_0000000000000001, 4'h3);
      for (int k = 0; k < 20; k++) rnd_req("R2", 1'b1, 2'($urandom_range(0, 2)), 1'b0, 4'h3);
      // R4 scalar broadcast; op_a_vec is noise
      for (int k = 0; k < 20; k++) begin
         rnd_req("R4", 1'b0, 2'($urandom_range(0, 3)), 1'b1, 4'hF);
         rnd_req("R4", 1'b1, 2'($urandom_range(0, 3)), 1'b1, 4'h3);
      end
      // R5 masks, including upper bits only in wide mode
      drive("R5", 1'b1, 1'b0, 2'b00, 1'b0, 16'h0, '1, '1, rnd_acc(), 4'h0);
      drive("R5", 1'b1, 1'b1, 2'b01, 1'b0, 16'h0, '1, '1, rnd_acc(), 4'hC);
      for (int k = 0; k < 20; k++) rnd_req("R5", 1'($urandom), 2'($urandom_range(0, 2)), 1'b0, 4'($urandom));
      // R7 wrap at the top of both accumulator widths
      drive("R7", 1'b1, 1'b0, 2'b00, 1'b0, 16'h0, '1, '1, '1, 4'hF);
      drive("R7", 1'b1, 1'b1, 2'b00, 1'b0, 16'h0, '1, '1, '1, 4'h3);
      drive("R7", 1'b1, 1'b1, 2'b01, 1'b0, 16'h0, 32'h80008000, 32'h80008000,
            128'h7FFFFFFFFFFFFFFF_7FFFFFFFFFFFFFFF, 4'h3);
      // R6 unsigned-A/signed-B with vector source
      drive("R6", 1'b1, 1'b0, 2'b11, 1'b0, 16'h0, '1, '1, rnd_acc(), 4'hF);
      drive("R6", 1'b1, 1'b1, 2'b11, 1'b0, 16'h0, '1, '1, rnd_acc(), 4'hF);
      rnd_req("R6", 1'b0, 2'b11, 1'b0, 4'hF);
      // R8 idle cycles with noisy inputs, then back-to-back requests
      rnd_req("R8", 1'b0, 2'b01, 1'b0, 4'hF);
      for (int k = 0; k < 5; k++)
         drive("R8", 1'b0, 1'($urandom), 2'($urandom), 1'($urandom), 16'($urandom),
               $urandom, $urandom, rnd_acc(), 4'($urandom));
      for (int k = 0; k < 6; k++) rnd_req("R8", 1'b0, 2'b00, 1'b0, 4'hF);
      // R10 wide requests on both instances (narrow-only one rejects)
      for (int k = 0; k < 10; k++) rnd_req("R10", 1'b1, 2'($urandom_range(0, 2)), 1'b0, 4'hF);
      drive("R8", 1'b0, 1'b0, 2'b00, 1'b0, 16'h0, '0, '0, '0, '0);
      drive("R8", 1'b0, 1'b0, 2'b00, 1'b0, 16'h0, '0, '0, '0, '0);
      finish_run();
   end
endmodule